// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache Controller

This block places a single-level data cache between a processor load/store port and a slower block-wide memory port. Each request carries a 32-bit byte address and, for stores, one 32-bit word. The cache keeps 1024 lines of four 32-bit words, so 16 KB of data, and each line has its own tag, a valid flag and a modified flag. A load or store that finds its line completes after one cycle. On a miss the controller first copies back a modified victim line, then fetches the wanted line, then applies the original access as a hit.

Stores are kept in the cache and reach memory only when their line is evicted. A store that misses fetches the line first and merges its word afterwards. The controller serves one access at a time. The processor waits with its ready input low until that access is done, and the controller ignores further request strobes until it is idle again.

Top module: `wbc_top`

## Requirements
- R1: After reset no line is valid, `cpu_ready` and `mem_valid` are low, and the first access to any address misses and reads the memory once.
- R2: Address bits 31..14 form the tag, bits 13..4 choose the line and bits 3..2 choose the word inside it. Lines that share bits 13..4 but differ in tag evict each other. Every memory address has bits 3..0 at zero, and a refill uses request address bits 31..4.
- R3: A load that hits returns the stored word with `cpu_ready` high in the cycle after the request, and it starts no memory transfer.
- R4: A store that hits replaces only the selected word and marks the line modified. It starts no memory transfer, so memory keeps the old copy.
- R5: A store that misses reads the whole line from memory, then writes its word. The other three words keep the values from memory.
- R6: On a miss to a line whose victim is modified, the controller writes the victim's 128-bit contents to the victim's own address (old tag, same line number). It does this before it issues the refill read. The refilled line is clean.
- R7: A miss whose victim is clean or invalid issues only the refill read and no write.
- R8: While an access is in progress `cpu_ready` stays low and no memory transfer overlaps a completion. A request strobe given during that time is discarded and changes no stored data.
- R9: The controller holds `mem_valid`, `mem_we` and `mem_addr` steady until `mem_ready`. In the 128-bit block, word k (k = 0..3, chosen by address bits 3..2) sits in bits 32k+31..32k.
- R10: `cpu_ready` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Request strobe, sampled only when idle |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store word |
| cpu_rdata | output | 32 | Load word, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a line write-back, 0 for a refill |
| mem_addr | output | 32 | Line-aligned memory byte address |
| mem_wdata | output | 128 | Line written back |
| mem_rdata | input | 128 | Line returned by a refill |
| mem_ready | input | 1 | Memory completion, one cycle |

## Verification
The properties assume that the memory raises `mem_ready` only while `mem_valid` is high, and only for one cycle per transfer. They also assume that the processor keeps at most one access in flight. The bench's memory model answers only an open request, after 1 to 4 cycles, and drops `mem_ready` on the next cycle. The processor driver waits for each completion before it issues the next request. The one deliberate stray strobe is sent while a miss is in progress, and the checks that follow show that it had no effect.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMP   = 2'd1,
        ST_WB    = 2'd2,
        ST_ALLOC = 2'd3
    } wbc_state_e;
endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
    parameter int LINES  = 1024,
    parameter int TAG_W  = 18,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W  = $clog2(LINES),
    localparam int SEL_W  = $clog2(WORDS),
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [SEL_W-1:0]  sel,
    input  logic              fill_en,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_data,
    output logic [TAG_W-1:0]  line_tag,
    output logic              line_valid,
    output logic              line_dirty,
    output logic [LINE_W-1:0] line_data
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // flags are the only reset state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (word_we) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx] <= fill_tag;
        end
    end

    // one storage lane per word of the line
    for (genvar w = 0; w < WORDS; w++) begin : g_lane
        logic [WORD_W-1:0] lane_q [LINES];

        always_ff @(posedge clk) begin
            if (fill_en) begin
                lane_q[idx] <= fill_line[w*WORD_W +: WORD_W];
            end else if (word_we && (sel == SEL_W'(w))) begin
                lane_q[idx] <= word_data;
            end
        end

        assign line_data[w*WORD_W +: WORD_W] = lane_q[idx];
    end

    assign line_tag   = tag_q[idx];
    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic              mem_ready,
    output logic              cpu_ready,
    output logic              word_we,
    output logic              fill_en,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] req_addr,
    output logic [WORD_W-1:0] req_wdata
);
    typedef struct packed {
        wbc_state_e        st;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d    = ctrl_q;
        cpu_ready = 1'b0;
        word_we   = 1'b0;
        fill_en   = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        unique case (ctrl_q.st)
            ST_IDLE: begin
                if (cpu_valid) begin
                    ctrl_d.st    = ST_CMP;
                    ctrl_d.we    = cpu_we;
                    ctrl_d.addr  = cpu_addr;
                    ctrl_d.wdata = cpu_wdata;
                end
            end
            ST_CMP: begin
                if (hit) begin
                    cpu_ready = 1'b1;
                    word_we   = ctrl_q.we;
                    ctrl_d.st = ST_IDLE;
                end else if (victim_dirty) begin
                    ctrl_d.st = ST_WB;
                end else begin
                    ctrl_d.st = ST_ALLOC;
                end
            end
            ST_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                if (mem_ready) begin
                    ctrl_d.st = ST_ALLOC;
                end
            end
            ST_ALLOC: begin
                mem_valid = 1'b1;
                if (mem_ready) begin
                    fill_en   = 1'b1;
                    ctrl_d.st = ST_CMP;
                end
            end
            default: ctrl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{st: ST_IDLE, we: 1'b0, addr: '0, wdata: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign req_addr  = ctrl_q.addr;
    assign req_wdata = ctrl_q.wdata;
endmodule

// File: rtl/wbc_top.sv
module wbc_top #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 1024,
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int SEL_W  = $clog2(WORDS);
    localparam int OFF_W  = $clog2(LINE_W / 8);
    localparam int BYTE_W = OFF_W - SEL_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic [ADDR_W-1:0] req_addr;
    logic [WORD_W-1:0] req_wdata;
    logic              hit, word_we, fill_en;
    logic [TAG_W-1:0]  line_tag;
    logic              line_valid, line_dirty;
    logic [LINE_W-1:0] line_data;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [SEL_W-1:0]  req_sel;
    logic [BYTE_W-1:0] unused_byte;

    assign req_tag     = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx     = req_addr[OFF_W +: IDX_W];
    assign req_sel     = req_addr[BYTE_W +: SEL_W];
    assign unused_byte = req_addr[BYTE_W-1:0];

    assign hit = line_valid && (line_tag == req_tag);

    wbc_ctrl #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_valid    (cpu_valid),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .hit          (hit),
        .victim_dirty (line_valid && line_dirty),
        .mem_ready    (mem_ready),
        .cpu_ready    (cpu_ready),
        .word_we      (word_we),
        .fill_en      (fill_en),
        .mem_valid    (mem_valid),
        .mem_we       (mem_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata)
    );

    wbc_line_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .WORD_W (WORD_W),
        .WORDS  (WORDS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .sel        (req_sel),
        .fill_en    (fill_en),
        .fill_tag   (req_tag),
        .fill_line  (mem_rdata),
        .word_we    (word_we),
        .word_data  (req_wdata),
        .line_tag   (line_tag),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_data  (line_data)
    );

    // write-back targets the victim's tag, refill the request's tag
    assign mem_addr  = {(mem_we ? line_tag : req_tag), req_idx, {OFF_W{1'b0}}};
    assign mem_wdata = line_data;
    assign cpu_rdata = line_data[req_sel*WORD_W +: WORD_W];
endmodule

// File: rtl/wbc_chk.sv
module wbc_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int LINES  = 1024,
    localparam int LINE_W = WORD_W * WORDS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic              cpu_we,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [WORD_W-1:0] cpu_wdata,
    input logic [WORD_W-1:0] cpu_rdata,
    input logic              cpu_ready,
    input logic              mem_valid,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LINE_W-1:0] mem_wdata,
    input logic [LINE_W-1:0] mem_rdata,
    input logic              mem_ready
);
    localparam int OFF_W = $clog2(LINE_W / 8);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R6
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we && mem_ready) |=> (mem_valid && !mem_we));

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && mem_valid));

    // R2
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

    // R7
    fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && mem_ready) |=> !mem_valid);
endmodule

bind wbc_top wbc_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .WORDS  (WORDS),
    .LINES  (LINES)
) u_chk (.*);

// File: tb/wbc_top_tb.sv
module wbc_top_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_valid = 1'b0;
    logic         cpu_we = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         mem_valid;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ready = 1'b0;

    always #4 clk = ~clk;

    wbc_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .mem_valid (mem_valid),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench memory, golden word view and expected line state
    logic [127:0] mem_store [logic [27:0]];
    logic [31:0]  gold [logic [29:0]];
    bit           exp_v [int];
    bit           exp_d [int];
    logic [17:0]  exp_t [int];

    int           n_wr, n_rd;
    bit           wr_before_rd;
    logic [31:0]  last_wr_addr, last_rd_addr;
    logic [127:0] last_wr_data;

    function automatic logic [31:0] dflt(logic [29:0] wa);
        return ({2'b00, wa} * 32'h9E3779B9) ^ 32'h5A5A0000;
    endfunction

    function automatic logic [31:0] gold_word(logic [29:0] wa);
        if (gold.exists(wa)) return gold[wa];
        return dflt(wa);
    endfunction

    function automatic logic [127:0] gold_line(logic [27:0] blk);
        logic [127:0] l;
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = gold_word({blk, 2'(k)});
        return l;
    endfunction

    function automatic logic [127:0] mem_line(logic [27:0] blk);
        logic [127:0] l;
        if (mem_store.exists(blk)) return mem_store[blk];
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = dflt({blk, 2'(k)});
        return l;
    endfunction

    task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: answers an open request after 1..4 cycles
    initial begin
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            if (rst_n && mem_valid) begin
                int lat;
                lat = 1 + int'($urandom_range(0, 3));
                repeat (lat - 1) @(negedge clk);
                if (mem_we) begin
                    mem_store[mem_addr[31:4]] = mem_wdata;
                    n_wr++;
                    last_wr_addr = mem_addr;
                    last_wr_data = mem_wdata;
                end else begin
                    mem_rdata = mem_line(mem_addr[31:4]);
                    n_rd++;
                    wr_before_rd = (n_wr > 0);
                    last_rd_addr = mem_addr;
                end
                mem_ready = 1'b1;
            end
        end
    end

    task automatic do_op(bit we, logic [31:0] addr, logic [31:0] wdata, bit inj,
                         logic [31:0] inj_addr);
        int idx;
        bit pred_hit, pred_dirty;
        logic [31:0] victim;
        logic [31:0] rd;
        int cyc;
        idx = int'(addr[13:4]);
        pred_hit = exp_v.exists(idx) && exp_v[idx] && exp_t[idx] == addr[31:14];
        pred_dirty = !pred_hit && exp_v.exists(idx) && exp_v[idx] && exp_d[idx];
        victim = exp_t.exists(idx) ? {exp_t[idx], addr[13:4], 4'h0} : 32'h0;
        n_wr = 0; n_rd = 0; wr_before_rd = 1'b0;
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
        @(negedge clk);
        cpu_valid = 1'b0;
        cyc = 1;
        while (!cpu_ready && cyc < 200) begin
            if (inj && cyc == 1) begin
                cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = inj_addr; cpu_wdata = 32'hDEADBEEF;
            end
            @(negedge clk);
            cpu_valid = 1'b0;
            cyc++;
        end
        chk(cpu_ready, "R8", "access never completed", 128'(cpu_ready), 128'(1));
        rd = cpu_rdata;
        if (pred_hit) begin
            chk(cyc == 1, "R3", "hit latency", 128'(cyc), 128'(1));
            chk(n_wr == 0 && n_rd == 0, "R4", "hit caused memory traffic",
                128'(n_wr + n_rd), 128'(0));
        end else if (pred_dirty) begin
            chk(n_wr == 1 && n_rd == 1 && wr_before_rd, "R6", "write-back then refill",
                128'({n_wr[7:0], n_rd[7:0]}), 128'(16'h0101));
            chk(last_wr_addr == victim, "R6", "victim address", 128'(last_wr_addr), 128'(victim));
            chk(last_wr_data == gold_line(victim[31:4]), "R6", "victim data",
                last_wr_data, gold_line(victim[31:4]));
            chk(last_rd_addr == {addr[31:4], 4'h0}, "R2", "refill address",
                128'(last_rd_addr), 128'({addr[31:4], 4'h0}));
        end else begin
            chk(n_wr == 0 && n_rd == 1, "R7", "clean miss traffic",
                128'({n_wr[7:0], n_rd[7:0]}), 128'(16'h0001));
            chk(last_rd_addr == {addr[31:4], 4'h0}, "R2", "refill address",
                128'(last_rd_addr), 128'({addr[31:4], 4'h0}));
        end
        if (!we) begin
            chk(rd == gold_word(addr[31:2]), "R3", "load data", 128'(rd), 128'(gold_word(addr[31:2])));
        end else begin
            gold[addr[31:2]] = wdata;
        end
        exp_v[idx] = 1'b1;
        exp_t[idx] = addr[31:14];
        exp_d[idx] = pred_hit ? (exp_d[idx] | we) : we;
        @(negedge clk);
        chk(!cpu_ready, "R10", "ready longer than one cycle", 128'(cpu_ready), 128'(0));
    endtask

    function automatic logic [31:0] mk(int tag, int idx, int w);
        return {14'(tag), 10'(idx), 2'(w), 2'b00};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!cpu_ready && !mem_valid, "R1", "outputs in reset",
            128'({cpu_ready, mem_valid}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_ready && !mem_valid, "R1", "outputs after reset",
            128'({cpu_ready, mem_valid}), 128'(0));
        // R1: first access misses
        do_op(1'b0, mk(0, 5, 1), 0, 1'b0, 0);
        chk(n_rd == 1, "R1", "first access reads memory", 128'(n_rd), 128'(1));
        do_op(1'b0, mk(0, 5, 3), 0, 1'b0, 0);          // R3 hit
        do_op(1'b1, mk(0, 5, 2), 32'h1234_5678, 1'b0, 0); // R4 write hit
        chk(mem_line(28'(mk(0, 5, 0) >> 4))[95:64] != 32'h1234_5678, "R4",
            "memory updated on write hit", mem_line(28'(mk(0, 5, 0) >> 4)), 128'(0));
        do_op(1'b0, mk(1, 5, 0), 0, 1'b0, 0);           // R2/R6 conflict evicts dirty
        chk(mem_line(28'(mk(0, 5, 0) >> 4))[95:64] == 32'h1234_5678, "R9",
            "word 2 lane in written-back block", mem_line(28'(mk(0, 5, 0) >> 4)),
            128'(32'h1234_5678) << 64);
        do_op(1'b0, mk(0, 5, 2), 0, 1'b0, 0);           // R7 clean victim
        do_op(1'b1, mk(2, 6, 1), 32'hCAFE_0001, 1'b0, 0); // R5 write miss
        do_op(1'b0, mk(2, 6, 0), 0, 1'b0, 0);           // R5 other word from memory
        do_op(1'b0, mk(2, 6, 1), 0, 1'b0, 0);
        // R8: stray strobe during a miss
        do_op(1'b0, mk(3, 7, 0), 0, 1'b1, mk(3, 8, 0));
        do_op(1'b0, mk(3, 8, 0), 0, 1'b0, 0);
        do_op(1'b0, mk(1, 1023, 3), 0, 1'b0, 0);
        for (int i = 0; i < 400; i++) begin
            int t, x, w;
            t = int'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
                0: x = 0;
                1: x = 1;
                2: x = 1023;
                default: x = int'($urandom_range(0, 7));
            endcase
            w = int'($urandom_range(0, 3));
            do_op(1'($urandom_range(0, 1)), mk(t, x, w), $urandom, 1'b0, 0);
        end
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule